// File: doc/BRIEF.md
# Paged Adapter Register Window

This block is the host-facing I/O glue of a network adapter. It decodes a 32-byte I/O window. The lowest eight bytes hold eight byte-wide glue control registers. The next eight bytes form a shared view. One control bit steers the view either to an attached network controller's 16-entry register file or to a small identification ROM. The ROM has two pages: one holds the maker, the card type, the revision and a mirror of three configuration bytes, and the other holds a 6-byte station address. The upper sixteen bytes of the window are reserved.

The controller register index is four bits wide, but the view shows only eight entries at a time. A page bit in a control register supplies the top index bit. Further control register bits drive the controller's reset line, a 16/4 Mb/s speed select and a cable-type select. Every read returns its data on the clock edge after the access. Controller accesses are passed on as single-cycle strobes.

Top module: `adapter_regwin`

## Requirements
- R1: After reset, control registers 0 to 7 read 0, the view shows the ID ROM, `ctl_run` is 0 (controller held in reset), `spd_16m` is 0 and `cable_utp` is 0.
- R2: A write to window offset 0 to 7 stores the low data byte in that control register. A read of that offset returns `{8'h00, value}` in `io_rdata` on the clock edge that follows the read.
- R3: While bit 2 of control register 0 is clear, a read of offset 8 to 15 returns a ROM byte with the upper 8 bits zero. Writes to those offsets reach no controller register (no `ctl_wr` strobe).
- R4: ROM page 0 (control register 0 bit 3 clear) holds, by offset: 0 = MAKER_ID (default 0x4D), 1 = CARD_TYPE, 2 = CARD_REV, 3/4/5 = `cfg_b0`/`cfg_b1`/`cfg_b2`, and 6 and 7 = 0.
- R5: ROM page 1 (control register 0 bit 3 set) holds 0 at offsets 0 and 7. Offsets 1 to 6 hold STATION_ADDR bytes 47:40 down to 7:0, most significant byte first.
- R6: While bit 2 of control register 0 is set, an access to offset 8+k reaches controller register `{p, k}`, where p is bit 1 of control register 1. A read returns the controller data on the edge after the read.
- R7: With `io_word` high, a controller access carries all 16 bits in both directions. With `io_word` low, `ctl_word` is low and a read returns the controller's low byte with the upper 8 bits zero.
- R8: `ctl_run` follows bit 0 of control register 1. Writing 0 holds the controller in reset, and writing 1 releases it.
- R9: `spd_16m` follows bit 2 of control register 1: 1 selects 16 Mb/s and 0 selects 4 Mb/s.
- R10: `cable_utp` follows bit 0 of control register 7: 1 selects UTP and 0 selects STP.
- R11: Offsets 16 to 31 read 0. Writes to them change no control register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_cs | input | 1 | Window select |
| io_addr | input | 5 | Byte offset in the window |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_word | input | 1 | 16-bit access when high |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Registered read data |
| cfg_b0 | input | 8 | Configuration byte 0, mirrored in the ROM |
| cfg_b1 | input | 8 | Configuration byte 1, mirrored in the ROM |
| cfg_b2 | input | 8 | Configuration byte 2, mirrored in the ROM |
| ctl_idx | output | 4 | Controller register index |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_word | output | 1 | Controller access is 16 bits |
| ctl_wdata | output | 16 | Controller write data |
| ctl_rdata | input | 16 | Controller read data, valid in the same cycle as the index |
| ctl_run | output | 1 | Controller reset release (0 = held in reset) |
| spd_16m | output | 1 | Ring speed select |
| cable_utp | output | 1 | Cable type select |

## Verification
The assertions assume that the host raises at most one of `io_rd` and `io_wr` in a cycle. They also assume that every strobe is qualified by `io_cs` and that inputs are stable around the clock edge. The controller stub returns its data combinationally from `ctl_idx`, which matches the one-cycle read return that the properties expect. The bench drives all inputs on the falling edge and performs one access at a time with idle cycles between accesses. Its random phase keeps the view mapped to the controller, so every random controller access has a defined result.

// File: rtl/adapter_regwin_pkg.sv
package adapter_regwin_pkg;
  // window regions, decoded from the two top offset bits
  typedef enum logic [1:0] {
    RGN_CTRL = 2'd0,
    RGN_VIEW = 2'd1,
    RGN_RSVD = 2'd2
  } region_e;

  // control register 0 fields
  localparam int MAP_BIT    = 2;  // 1: controller, 0: ID ROM
  localparam int ROMPG_BIT  = 3;  // ROM page select
  // control register 1 fields
  localparam int RUN_BIT    = 0;  // controller reset release
  localparam int HIPG_BIT   = 1;  // top bit of controller index
  localparam int SPEED_BIT  = 2;  // 16 Mb/s when set
  // control register 7 fields
  localparam int CABLE_BIT  = 0;  // UTP when set

  localparam int REG_MODE0  = 0;
  localparam int REG_MODE1  = 1;
  localparam int REG_MEDIA  = 7;
endpackage

// File: rtl/adapter_decode.sv
module adapter_decode
  import adapter_regwin_pkg::*;
#(
  parameter int BANK_AW = 3,
  localparam int WIN_AW = BANK_AW + 2
) (
  input  logic [WIN_AW-1:0] addr,
  output region_e           region,
  output logic [BANK_AW-1:0] idx
);
  always_comb begin
    idx = addr[BANK_AW-1:0];
    unique case (addr[WIN_AW-1:BANK_AW])
      2'b00:   region = RGN_CTRL;
      2'b01:   region = RGN_VIEW;
      default: region = RGN_RSVD;
    endcase
  end
endmodule

// File: rtl/adapter_ctlregs.sv
module adapter_ctlregs #(
  parameter int BANK_AW = 3,
  parameter int BW      = 8,
  localparam int NREG   = 1 << BANK_AW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [BANK_AW-1:0]      wr_idx,
  input  logic [BW-1:0]           wr_data,
  output logic [NREG-1:0][BW-1:0] regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wr_en && (wr_idx == BANK_AW'(g)))
        regs[g] <= wr_data;
    end
  end
endmodule

// File: rtl/adapter_idrom.sv
module adapter_idrom #(
  parameter int          BANK_AW      = 3,
  parameter logic [7:0]  MAKER_ID     = 8'h4D,
  parameter logic [7:0]  CARD_TYPE    = 8'h08,
  parameter logic [7:0]  CARD_REV     = 8'h03,
  parameter logic [47:0] STATION_ADDR = 48'h02A4_1C7E_9B35,
  localparam int         NENT         = 1 << BANK_AW,
  localparam int         ADDR_BYTES   = 6
) (
  input  logic               page,
  input  logic [BANK_AW-1:0] idx,
  input  logic [7:0]         cfg_b0,
  input  logic [7:0]         cfg_b1,
  input  logic [7:0]         cfg_b2,
  output logic [7:0]         data
);
  logic [NENT-1:0][7:0] pg0;
  logic [NENT-1:0][7:0] pg1;

  always_comb begin
    pg0    = '0;
    pg0[0] = MAKER_ID;
    pg0[1] = CARD_TYPE;
    pg0[2] = CARD_REV;
    pg0[3] = cfg_b0;
    pg0[4] = cfg_b1;
    pg0[5] = cfg_b2;
  end

  // page 1: entry 0 empty, then the address bytes, most significant first
  for (genvar g = 0; g < NENT; g++) begin : g_pg1
    if (g >= 1 && g <= ADDR_BYTES) begin : g_addr
      assign pg1[g] = STATION_ADDR[8*(ADDR_BYTES-g) +: 8];
    end else begin : g_zero
      assign pg1[g] = 8'h00;
    end
  end

  assign data = page ? pg1[idx] : pg0[idx];
endmodule

// File: rtl/adapter_regwin.sv
module adapter_regwin
  import adapter_regwin_pkg::*;
#(
  parameter int          BANK_AW      = 3,
  parameter int          DW           = 16,
  parameter logic [7:0]  MAKER_ID     = 8'h4D,
  parameter logic [7:0]  CARD_TYPE    = 8'h08,
  parameter logic [7:0]  CARD_REV     = 8'h03,
  parameter logic [47:0] STATION_ADDR = 48'h02A4_1C7E_9B35,
  localparam int         WIN_AW       = BANK_AW + 2,
  localparam int         CIW          = BANK_AW + 1,
  localparam int         NREG         = 1 << BANK_AW,
  localparam int         BW           = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_cs,
  input  logic [WIN_AW-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_word,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic [7:0]        cfg_b0,
  input  logic [7:0]        cfg_b1,
  input  logic [7:0]        cfg_b2,
  output logic [CIW-1:0]    ctl_idx,
  output logic              ctl_rd,
  output logic              ctl_wr,
  output logic              ctl_word,
  output logic [DW-1:0]     ctl_wdata,
  input  logic [DW-1:0]     ctl_rdata,
  output logic              ctl_run,
  output logic              spd_16m,
  output logic              cable_utp
);
  region_e                   region;
  logic [BANK_AW-1:0]        bidx;
  logic [NREG-1:0][BW-1:0]   cregs;
  logic [7:0]                rom_byte;
  logic                      map_ctl;
  logic                      rom_page;
  logic                      hipage;
  logic                      cr_wr;
  logic                      rd_hit;

  adapter_decode #(.BANK_AW(BANK_AW)) u_dec (
    .addr   (io_addr),
    .region (region),
    .idx    (bidx)
  );

  assign cr_wr = io_cs && io_wr && (region == RGN_CTRL);

  adapter_ctlregs #(.BANK_AW(BANK_AW), .BW(BW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cr_wr),
    .wr_idx  (bidx),
    .wr_data (io_wdata[BW-1:0]),
    .regs    (cregs)
  );

  assign map_ctl   = cregs[REG_MODE0][MAP_BIT];
  assign rom_page  = cregs[REG_MODE0][ROMPG_BIT];
  assign hipage    = cregs[REG_MODE1][HIPG_BIT];
  assign ctl_run   = cregs[REG_MODE1][RUN_BIT];
  assign spd_16m   = cregs[REG_MODE1][SPEED_BIT];
  assign cable_utp = cregs[REG_MEDIA][CABLE_BIT];

  adapter_idrom #(
    .BANK_AW      (BANK_AW),
    .MAKER_ID     (MAKER_ID),
    .CARD_TYPE    (CARD_TYPE),
    .CARD_REV     (CARD_REV),
    .STATION_ADDR (STATION_ADDR)
  ) u_rom (
    .page   (rom_page),
    .idx    (bidx),
    .cfg_b0 (cfg_b0),
    .cfg_b1 (cfg_b1),
    .cfg_b2 (cfg_b2),
    .data   (rom_byte)
  );

  // controller access strobes, forwarded in the access cycle
  assign ctl_idx   = {hipage, bidx};
  assign ctl_rd    = io_cs && io_rd && (region == RGN_VIEW) && map_ctl;
  assign ctl_wr    = io_cs && io_wr && (region == RGN_VIEW) && map_ctl;
  assign ctl_word  = io_word;
  assign ctl_wdata = io_wdata;

  assign rd_hit = io_cs && io_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (rd_hit) begin
      unique case (region)
        RGN_CTRL: io_rdata <= DW'(cregs[bidx]);
        RGN_VIEW: begin
          if (!map_ctl)
            io_rdata <= DW'(rom_byte);
          else if (io_word)
            io_rdata <= ctl_rdata;
          else
            io_rdata <= DW'(ctl_rdata[BW-1:0]);
        end
        default:  io_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adapter_regwin_chk.sv
module adapter_regwin_chk (
  input logic        clk,
  input logic        rst,
  input logic        io_cs,
  input logic [4:0]  io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [15:0] io_wdata,
  input logic [15:0] io_rdata,
  input logic        ctl_rd,
  input logic        ctl_wr,
  input logic        map_ctl,
  input logic        ctl_run,
  input logic        spd_16m,
  input logic        cable_utp
);
  // R3 / R6: controller strobes only with the view mapped to the controller
  p_ctl_needs_map_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd || ctl_wr) |-> (map_ctl && io_cs && io_addr[4:3] == 2'b01));

  // R3: ROM reads leave the upper byte zero
  p_rom_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (io_cs && io_rd && io_addr[4:3] == 2'b01 && !map_ctl) |=> (io_rdata[15:8] == 8'h00));

  // R8: the controller leaves reset only through a write of control register 1
  p_run_by_write_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_run) |-> $past(io_cs && io_wr && io_addr == 5'd1 && io_wdata[0]));

  // R9: speed select moves only on a control register 1 write
  p_speed_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(io_cs && io_wr && io_addr == 5'd1) |=> $stable(spd_16m));

  // R10: cable select moves only on a control register 7 write
  p_cable_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(io_cs && io_wr && io_addr == 5'd7) |=> $stable(cable_utp));

  // R11: reserved offsets read zero
  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (io_cs && io_rd && io_addr[4]) |=> (io_rdata == 16'h0000));
endmodule

bind adapter_regwin adapter_regwin_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_cs     (io_cs),
  .io_addr   (io_addr),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .ctl_rd    (ctl_rd),
  .ctl_wr    (ctl_wr),
  .map_ctl   (map_ctl),
  .ctl_run   (ctl_run),
  .spd_16m   (spd_16m),
  .cable_utp (cable_utp)
);

// File: tb/adapter_regwin_tb.sv
module adapter_regwin_tb;
  localparam logic [7:0]  T_MAKER = 8'h4D;
  localparam logic [7:0]  T_TYPE  = 8'h0D;
  localparam logic [7:0]  T_REV   = 8'h05;
  localparam logic [47:0] T_ADDR  = 48'h02A4_1C7E_9B35;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_cs = 0, io_rd = 0, io_wr = 0, io_word = 0;
  logic [4:0]  io_addr = '0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic [7:0]  cfg_b0 = 8'h5A, cfg_b1 = 8'hC3, cfg_b2 = 8'h17;
  logic [3:0]  ctl_idx;
  logic        ctl_rd, ctl_wr, ctl_word, ctl_run, spd_16m, cable_utp;
  logic [15:0] ctl_wdata, ctl_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  adapter_regwin #(
    .MAKER_ID(T_MAKER), .CARD_TYPE(T_TYPE), .CARD_REV(T_REV), .STATION_ADDR(T_ADDR)
  ) u_dut (
    .clk, .rst, .io_cs, .io_addr, .io_rd, .io_wr, .io_word, .io_wdata, .io_rdata,
    .cfg_b0, .cfg_b1, .cfg_b2, .ctl_idx, .ctl_rd, .ctl_wr, .ctl_word, .ctl_wdata,
    .ctl_rdata, .ctl_run, .spd_16m, .cable_utp
  );

  // controller stub: 16 registers, cleared and write-protected while held in reset
  logic [15:0] stub [16];
  assign ctl_rdata = stub[ctl_idx];
  always_ff @(posedge clk) begin
    if (!ctl_run) begin
      for (int i = 0; i < 16; i++) stub[i] <= '0;
    end else if (ctl_wr) begin
      if (ctl_word) stub[ctl_idx] <= ctl_wdata;
      else          stub[ctl_idx][7:0] <= ctl_wdata[7:0];
    end
  end

  // bench models
  logic [15:0] m_ctl [16];
  logic [7:0]  m_cr  [8];

  function automatic logic [7:0] rom_exp(input logic pg, input int off);
    if (!pg) begin
      case (off)
        0: return T_MAKER;
        1: return T_TYPE;
        2: return T_REV;
        3: return cfg_b0;
        4: return cfg_b1;
        5: return cfg_b2;
        default: return 8'h00;
      endcase
    end else begin
      if (off >= 1 && off <= 6) return T_ADDR[8*(6-off) +: 8];
      return 8'h00;
    end
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic w);
    @(negedge clk);
    io_cs = 1; io_wr = 1; io_addr = 5'(a); io_wdata = d; io_word = w;
    @(negedge clk);
    io_cs = 0; io_wr = 0; io_word = 0;
    if (a < 8) m_cr[a] = d[7:0];
  endtask

  task automatic rd(input int a, input logic w, output logic [15:0] q);
    @(negedge clk);
    io_cs = 1; io_rd = 1; io_addr = 5'(a); io_word = w;
    @(negedge clk);
    io_cs = 0; io_rd = 0; io_word = 0;
    q = io_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] q;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) m_ctl[i] = '0;
    for (int i = 0; i < 8; i++) m_cr[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 run", {15'd0, ctl_run}, 16'd0);
    check("R1 speed", {15'd0, spd_16m}, 16'd0);
    check("R1 cable", {15'd0, cable_utp}, 16'd0);
    for (int a = 0; a < 8; a++) begin
      rd(a, 0, q); check("R1 creg", q, 16'h0);
    end
    rd(8, 0, q); check("R1 rom mapped", q, {8'h0, T_MAKER});

    // R4: ROM page 0
    for (int a = 0; a < 8; a++) begin
      rd(8 + a, 1, q); check("R4 page0", q, {8'h0, rom_exp(0, a)});
    end
    // R5: ROM page 1
    wr(0, 16'h0008, 0);
    for (int a = 0; a < 8; a++) begin
      rd(8 + a, 1, q); check("R5 page1", q, {8'h0, rom_exp(1, a)});
    end

    // R2: readback with junk upper byte
    wr(3, 16'hFFA7, 1);
    rd(3, 0, q); check("R2 readback", q, 16'h00A7);

    // R8: controller held until released
    wr(0, 16'h0004, 0);
    wr(8 + 2, 16'h1111, 1);
    rd(8 + 2, 1, q); check("R8 held in reset", q, 16'h0000);
    wr(1, 16'h0001, 0);
    check("R8 released", {15'd0, ctl_run}, 16'd1);

    // R6 / R7: word and byte paths
    wr(8 + 2, 16'h1234, 1); m_ctl[2] = 16'h1234;
    rd(8 + 2, 1, q); check("R7 word", q, 16'h1234);
    wr(8 + 2, 16'hEE99, 0); m_ctl[2][7:0] = 8'h99;
    rd(8 + 2, 1, q); check("R7 byte write", q, 16'h1299);
    rd(8 + 2, 0, q); check("R7 byte read", q, 16'h0099);
    wr(1, 16'h0003, 0);
    wr(8 + 2, 16'hABCD, 1); m_ctl[10] = 16'hABCD;
    rd(8 + 2, 1, q); check("R6 high page", q, 16'hABCD);
    wr(1, 16'h0001, 0);
    rd(8 + 2, 1, q); check("R6 low page", q, 16'h1299);

    // R3: writes to the view while ROM mapped are dropped
    wr(0, 16'h0000, 0);
    wr(8 + 2, 16'hBEEF, 1);
    rd(8 + 2, 1, q); check("R3 rom read", q, {8'h0, T_REV});
    wr(0, 16'h0004, 0);
    rd(8 + 2, 1, q); check("R3 write ignored", q, 16'h1299);

    // R9 / R10
    wr(1, 16'h0005, 0);
    check("R9 16M", {15'd0, spd_16m}, 16'd1);
    wr(1, 16'h0001, 0);
    check("R9 4M", {15'd0, spd_16m}, 16'd0);
    wr(7, 16'h0001, 0);
    check("R10 utp", {15'd0, cable_utp}, 16'd1);
    wr(7, 16'h0000, 0);
    check("R10 stp", {15'd0, cable_utp}, 16'd0);

    // R11: reserved offsets
    wr(16 + 1, 16'h0000, 1);
    wr(16 + 7, 16'h00FF, 1);
    check("R11 run kept", {15'd0, ctl_run}, 16'd1);
    check("R11 cable kept", {15'd0, cable_utp}, 16'd0);
    rd(1, 0, q); check("R11 creg kept", q, 16'h0001);
    rd(16 + 5, 1, q); check("R11 read zero", q, 16'h0000);
    rd(31, 1, q); check("R11 read zero top", q, 16'h0000);

    // random phase, view mapped to controller, run kept
    for (int it = 0; it < 400; it++) begin
      int op, k;
      logic [15:0] d;
      logic hp;
      op = $urandom % 5;
      k  = $urandom % 8;
      d  = 16'($urandom);
      case (op)
        0: if (k >= 2 && k <= 6) wr(k, d, $urandom % 2);
        1: begin rd(k, 0, q); check("R2 rand readback", q, {8'h0, m_cr[k]}); end
        2: begin
             hp = 1'($urandom);
             wr(1, {13'd0, 1'($urandom), hp, 1'b1}, 0);
             if ($urandom % 2) begin
               wr(8 + k, d, 1); m_ctl[{hp, 3'(k)}] = d;
             end else begin
               wr(8 + k, d, 0); m_ctl[{hp, 3'(k)}][7:0] = d[7:0];
             end
           end
        3: begin
             hp = m_cr[1][1];
             rd(8 + k, 1, q); check("R6 rand word", q, m_ctl[{hp, 3'(k)}]);
           end
        default: begin
             hp = m_cr[1][1];
             rd(8 + k, 0, q); check("R7 rand byte", q, {8'h0, m_ctl[{hp, 3'(k)}][7:0]});
           end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule